// File: doc/BRIEF.md
# Infrared Edge Interval Timer

This block measures the spacing between edges of an infrared receiver output so that software can decode any remote-control protocol itself. The input is synchronised and cleaned by a majority-free unanimity filter, then a capture state machine watches for the edge kind chosen by software. On each chosen edge it stores the number of ticks that have passed since the previous chosen edge, together with a flag telling whether the level that just finished was low (a mark from an active-low receiver) or high (a space). It then restarts its counters and raises a level interrupt.

Software programs the tick length in clock cycles, picks rising, falling or both edges as the trigger, and enables capture. Reading the status word returns the mark/space flag and drops the interrupt. The control word returns the stored interval. The interval counter stops at its largest value, so a long idle gap reads as a timeout rather than a wrapped small number.

The capture state machine has three states. `ST_OFF` holds the counters cleared while capture is disabled. Setting the enable bit moves it to `ST_ARM` (transition *arm*), where the first chosen edge only starts timing and moves it to `ST_TIME` (transition *start*). In `ST_TIME` each chosen edge latches a capture and stays (transition *capture*). Clearing the enable bit returns any state to `ST_OFF` (transition *stop*).

Top module: `ir_edge_timer`

## Requirements
- R1: After reset `irq` is 0, the control word (address 0) reads 0, the status word (address 1) reads 0 and the tick word (address 2) reads the `DIV_RESET` parameter.
- R2: A change of `ir_in` that lasts fewer than `FILT_LEN` clock cycles is ignored: it produces no capture and does not restart the interval.
- R3: The stored interval equals floor(N / (D+1)), where N is the number of clock cycles between two consecutive chosen edges of `ir_in` and D is the tick word, bits 15:0 of address 2.
- R4: The interval stops at 8191 (all ones in 13 bits): a gap of 8191 or more ticks reads 8191, a gap of 8190 ticks reads 8190.
- R5: Status bit 8 reads 1 when the level that the captured edge ended was low and 0 when it was high.
- R6: Control bits 3:2 pick the trigger: 1 = both edges, 2 = falling only, 3 = rising only; edges of the other kind neither capture nor restart the interval.
- R7: With control bits 3:2 equal to 0 no edge ever captures or raises `irq`.
- R8: `irq` rises one cycle after a capture and stays high until a read of address 1 (`reg_rd` high with `reg_addr` = 1); a capture in the same cycle as that read keeps it high.
- R9: The first chosen edge after the enable bit (control bit 15) is set only starts timing and raises no interrupt.
- R10: With the enable bit clear, edges cause no capture and no interrupt, and the stored interval keeps its last value.
- R11: The control word reads the stored interval in bits 28:16, the enable bit in bit 15 and the trigger select in bits 3:2; writes to address 0 set bit 15 and bits 3:2, writes to address 2 set the tick word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ir_in | input | 1 | Raw receiver output, asynchronous, idles high |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears the interrupt at address 1) |
| reg_addr | input | 2 | Word address: 0 control, 1 status, 2 tick |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from `reg_addr` |
| irq | output | 1 | Level interrupt, set on capture |

## Verification
The bench keeps the default filter length of 3 and the 13-bit interval, and reprograms the tick word at run time. A tick word of 3 gives four-cycle ticks, so rounding down of odd cycle counts becomes visible in short gaps of a few dozen cycles. A tick word of 0 makes every cycle a tick, which brings the 8191 stop value, and the gaps just below and above it, within a few thousand cycles each.

// File: rtl/ir_cap_pkg.sv
package ir_cap_pkg;

    typedef enum logic [1:0] {
        SEL_FRAME = 2'd0,
        SEL_BOTH  = 2'd1,
        SEL_FALL  = 2'd2,
        SEL_RISE  = 2'd3
    } edge_sel_e;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_ARM  = 2'd1,
        ST_TIME = 2'd2
    } cap_state_e;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_STAT = 2'd1;
    localparam logic [1:0] ADDR_TICK = 2'd2;

    localparam int CTRL_EN_BIT  = 15;
    localparam int CTRL_SEL_LSB = 2;
    localparam int CTRL_IV_LSB  = 16;
    localparam int STAT_POL_BIT = 8;

endpackage

// File: rtl/ir_in_filter.sv
module ir_in_filter #(
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic clean
);

    logic [1:0]          sync_q;
    logic [FILT_LEN-1:0] hist_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
            hist_q <= '1;
            clean  <= 1'b1;
        end else begin
            sync_q <= {sync_q[0], raw};
            hist_q <= {hist_q[FILT_LEN-2:0], sync_q[1]};
            if (&hist_q)
                clean <= 1'b1;
            else if (~|hist_q)
                clean <= 1'b0;
        end
    end

    AST_FILT_UNANIMOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(clean) |-> ($past(&hist_q) || $past(~|hist_q))); // R2

endmodule

// File: rtl/ir_tick_gen.sv
module ir_tick_gen #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] pc_q;

    assign tick = (pc_q >= div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pc_q <= '0;
        else if (restart || tick)
            pc_q <= '0;
        else
            pc_q <= pc_q + 1'b1;
    end

    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div != '0) |=> (!tick || div == '0)); // R3

endmodule

// File: rtl/ir_edge_fsm.sv
module ir_edge_fsm
    import ir_cap_pkg::*;
#(
    parameter int CNT_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  edge_sel_e        sel,
    input  logic             level,
    input  logic             tick,
    output logic             restart,
    output logic             capture,
    output logic [CNT_W-1:0] cap_iv,
    output logic             cap_pulse
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    cap_state_e       state_q, state_d;
    logic             level_q;
    logic             rise, fall, hit;
    logic [CNT_W-1:0] cnt_q, cnt_step;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            level_q <= 1'b1;
        else
            level_q <= level;
    end

    assign rise = level & ~level_q;
    assign fall = ~level & level_q;

    always_comb begin
        unique case (sel)
            SEL_BOTH:  hit = rise | fall;
            SEL_FALL:  hit = fall;
            SEL_RISE:  hit = rise;
            SEL_FRAME: hit = 1'b0;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_OFF;
        else
            state_q <= state_d;
    end

    // Next state and outputs
    always_comb begin
        state_d = state_q;
        restart = 1'b0;
        capture = 1'b0;
        unique case (state_q)
            ST_OFF: begin
                restart = 1'b1;
                if (enable)
                    state_d = ST_ARM;
            end
            ST_ARM: begin
                restart = hit;
                if (!enable)
                    state_d = ST_OFF;
                else if (hit)
                    state_d = ST_TIME;
            end
            ST_TIME: begin
                if (!enable) begin
                    state_d = ST_OFF;
                end else if (hit) begin
                    capture = 1'b1;
                    restart = 1'b1;
                end
            end
            default: begin
                state_d = ST_OFF;
                restart = 1'b1;
            end
        endcase
    end

    assign cnt_step = (tick && cnt_q != CNT_MAX) ? cnt_q + 1'b1 : cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (restart)
            cnt_q <= '0;
        else
            cnt_q <= cnt_step;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_iv    <= '0;
            cap_pulse <= 1'b0;
        end else if (capture) begin
            cap_iv    <= cnt_step;
            cap_pulse <= ~level_q;
        end
    end

    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> ($stable(cap_iv) && $stable(cap_pulse))); // R10
    AST_NO_CAP_UNTIMED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_TIME) |-> !capture); // R9
    AST_FRAME_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_FRAME) |-> !capture); // R7
    AST_FALL_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && sel == SEL_FALL) |=> !cap_pulse); // R5
    AST_RISE_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && sel == SEL_RISE) |=> cap_pulse); // R5
    AST_CNT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_MAX && !restart) |=> cnt_q == CNT_MAX); // R4

endmodule

// File: rtl/ir_edge_timer.sv
module ir_edge_timer
    import ir_cap_pkg::*;
#(
    parameter int FILT_LEN  = 3,
    parameter int DIV_W     = 16,
    parameter int CNT_W     = 13,
    parameter int DIV_RESET = 999
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ir_in,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        irq
);

    localparam logic [DIV_W-1:0] DIV_INIT = DIV_W'(DIV_RESET);

    logic             en_q;
    edge_sel_e        sel_q;
    logic [DIV_W-1:0] div_q;
    logic             clean, tick, restart, capture, cap_pulse;
    logic [CNT_W-1:0] cap_iv;
    logic             stat_read;
    logic             unused_wdata;

    assign unused_wdata = ^reg_wdata;
    assign stat_read    = reg_rd && (reg_addr == ADDR_STAT);

    ir_in_filter #(.FILT_LEN(FILT_LEN)) u_filter (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   (ir_in),
        .clean (clean)
    );

    ir_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .div     (div_q),
        .tick    (tick)
    );

    ir_edge_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (en_q),
        .sel       (sel_q),
        .level     (clean),
        .tick      (tick),
        .restart   (restart),
        .capture   (capture),
        .cap_iv    (cap_iv),
        .cap_pulse (cap_pulse)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            sel_q <= SEL_FRAME;
            div_q <= DIV_INIT;
        end else if (reg_wr) begin
            if (reg_addr == ADDR_CTRL) begin
                en_q  <= reg_wdata[CTRL_EN_BIT];
                sel_q <= edge_sel_e'(reg_wdata[CTRL_SEL_LSB +: 2]);
            end else if (reg_addr == ADDR_TICK) begin
                div_q <= reg_wdata[DIV_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            irq <= 1'b0;
        else if (capture)
            irq <= 1'b1;
        else if (stat_read)
            irq <= 1'b0;
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_CTRL: begin
                reg_rdata[CTRL_IV_LSB +: CNT_W]  = cap_iv;
                reg_rdata[CTRL_EN_BIT]           = en_q;
                reg_rdata[CTRL_SEL_LSB +: 2]     = sel_q;
            end
            ADDR_STAT: reg_rdata[STAT_POL_BIT]   = cap_pulse;
            ADDR_TICK: reg_rdata[DIV_W-1:0]      = div_q;
            default:   reg_rdata                 = '0;
        endcase
    end

    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !stat_read) |=> irq); // R8
    AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_read && !capture) |=> !irq); // R8
    AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> irq); // R8
    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> !capture); // R10

endmodule

// File: tb/ir_edge_timer_bench.sv
module ir_edge_timer_bench;

    typedef struct {
        int    iv;
        bit    pol;
        string tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ir_in = 1'b1;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        irq;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    exp_t q[$];
    bit   mon_on = 1'b0;

    int cur_sel = 0;
    int cur_d = 1000;
    bit armed = 1'b0;
    int last = 0;

    ir_edge_timer u_ir_edge_timer (
        .clk(clk), .rst_n(rst_n), .ir_in(ir_in), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string req, input longint act, input longint exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input bit strobe, output logic [31:0] d);
        reg_addr = a; reg_rd = strobe;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic set_ctrl(input bit en, input int sel);
        wr(2'd0, {16'd0, en, 11'd0, sel[1:0], 2'b00});
        cur_sel = en ? sel : 0;
        armed = 1'b0;
        repeat (20) @(negedge clk);
    endtask

    task automatic toggle(input int gap, input string tag);
        bit old, sel_hit;
        int n;
        repeat (gap) @(negedge clk);
        old = ir_in;
        ir_in = ~ir_in;
        sel_hit = (cur_sel == 1) || (cur_sel == 2 && old) || (cur_sel == 3 && !old);
        if (sel_hit) begin
            if (armed) begin
                n = (cyc - last) / cur_d;
                if (n > 8191) n = 8191;
                q.push_back('{n, (old == 1'b0), tag});
            end
            armed = 1'b1;
            last = cyc;
        end
    endtask

    task automatic glitch();
        @(negedge clk); ir_in = ~ir_in;
        @(negedge clk); ir_in = ~ir_in;
    endtask

    task automatic quiet();
        repeat (60) @(negedge clk);
        while (q.size() != 0 || irq) @(negedge clk);
        repeat (5) @(negedge clk);
    endtask

    // Monitor: pops expected captures and compares them with what the design reports
    initial begin
        exp_t e;
        logic [31:0] d;
        forever begin
            @(negedge clk);
            if (mon_on && irq) begin
                if (q.size() == 0) begin
                    check("R6/R7/R9 spurious irq", 1, 0);
                    rd(2'd1, 1'b1, d);
                end else begin
                    e = q.pop_front();
                    repeat (2) @(negedge clk);
                    check({"R8 hold ", e.tag}, irq, 1);
                    rd(2'd0, 1'b0, d);
                    check({"R3 interval ", e.tag}, d[28:16], e.iv);
                    rd(2'd1, 1'b1, d);
                    check({"R5 polarity ", e.tag}, d[8], e.pol);
                    check({"R8 clear ", e.tag}, irq, 0);
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [12:0] kept;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 / R11 reset view
        check("R1 irq", irq, 0);
        rd(2'd0, 1'b0, d); check("R1 ctrl", d, 0);
        rd(2'd1, 1'b1, d); check("R1 status", d, 0);
        rd(2'd2, 1'b0, d); check("R1 tick", d, 999);

        // R3 R5 R6 R9: both edges, 4-cycle ticks
        wr(2'd2, 32'd3); cur_d = 4;
        rd(2'd2, 1'b0, d); check("R11 tick write", d, 3);
        mon_on = 1'b1;
        set_ctrl(1'b1, 1);
        toggle(40, "R9 first");
        toggle(41, "R3 both");
        toggle(64, "R3 both");
        toggle(50, "R5 both");
        toggle(103, "R6 both");
        quiet();

        // R2 glitch does not restart the interval
        toggle(40, "R2 pre");
        repeat (20) @(negedge clk);
        glitch();
        repeat (30) @(negedge clk);
        toggle(0, "R2 across glitch");
        quiet();

        // R6 falling only
        set_ctrl(1'b0, 0);
        set_ctrl(1'b1, 2);
        for (int i = 0; i < 6; i++) toggle(45, "R6 fall");
        quiet();

        // R6 rising only
        set_ctrl(1'b0, 0);
        set_ctrl(1'b1, 3);
        for (int i = 0; i < 3; i++) begin
            toggle(30, "R6 rise");
            toggle(70, "R6 rise");
        end
        quiet();
        rd(2'd0, 1'b0, d); kept = d[28:16];

        // R7 select 0 raises nothing
        wr(2'd0, 32'h0000_8000); cur_sel = 0;
        for (int i = 0; i < 4; i++) toggle(40, "R7");
        repeat (20) @(negedge clk);
        check("R7 irq", irq, 0);
        check("R7 queue", q.size(), 0);

        // R10 disabled: no capture, value kept
        set_ctrl(1'b0, 1);
        cur_sel = 0;
        for (int i = 0; i < 4; i++) toggle(40, "R10");
        repeat (20) @(negedge clk);
        check("R10 irq", irq, 0);
        rd(2'd0, 1'b0, d);
        check("R10 interval kept", d[28:16], kept);
        check("R11 enable bit", d[15], 0);
        check("R11 select field", d[3:2], 1);

        // R4 saturation with one-cycle ticks
        wr(2'd2, 32'd0); cur_d = 1;
        set_ctrl(1'b1, 1);
        toggle(40, "R4 arm");
        toggle(9000, "R4 over");
        toggle(8191, "R4 at");
        toggle(8190, "R4 below");
        quiet();

        check("R3 queue drained", q.size(), 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule